// File: doc/BRIEF.md
# Serial Flash Configuration Image Reader

This block is the master that pulls a configuration image out of a serial NOR flash after reset. On a `start` pulse it runs one clock cycle on SCK with the chip select still high, then pulls chip select low. It sends the read opcode 0x03 on IO0 and then the start address, and keeps reading for as long as the caller wants. Each assembled byte leaves on `byte_data` with a one-clock `byte_valid` strobe.

The first byte always arrives one bit per SCK cycle on IO1. While the read is running, the caller can ask for two or four bits per cycle through `width_req`. The new width is taken at a byte boundary, with chip select held low and no new command. At the end of the address phase the block releases IO0 so that the flash can drive it. A per-read option chooses whether data are sampled on the rising SCK edge or half a period later on the falling edge. Another option selects a 24-bit or 32-bit address. The SCK rate is a power-of-two division of the system clock. A `stop` request ends the read once the byte in progress is complete.

Top module: `spi_cfg_reader`

## Requirements
- R1: After reset and while idle: `cs_n`=1, `sck`=0, `io0_oe`=0, `busy`=0 and `byte_valid`=0.
- R2: After `start`, exactly one SCK rising edge occurs with `cs_n` high. `cs_n` then falls in the same cycle that SCK returns low, and IO0 is driven from that point.
- R3: The command is opcode 0x03 followed by the address. Both go out MSB first on `io0_o`, which changes only when SCK falls. The flash samples each bit on the next rising edge.
- R4: With `addr32`=0 the address phase sends `start_addr[23:0]` (24 bits). With `addr32`=1 it sends all 32 bits of `start_addr`.
- R5: The first data byte is always received one bit per cycle on `io1_i`, MSB first, whatever `width_req` holds.
- R6: The `width_req` codes are: 2'b00 for x1 (`io1_i`), 2'b01 for x2 (pair {`io1_i`,`io0_i`}), and 2'b10 or 2'b11 for x4 (nibble {`io3_i`,`io2_i`,`io1_i`,`io0_i`}). Bits received earlier are more significant.
- R7: `width_req` is sampled in the cycle each byte completes and sets the width of the next byte only. `cs_n` stays low across the change, and no command bits are sent again.
- R8: `io0_oe` falls on the SCK falling edge that ends the last address bit. The block never drives IO0 while the flash returns x2 or x4 data.
- R9: With `fall_capture`=0, data are sampled on SCK rising edges and `byte_valid` is seen with SCK high. With `fall_capture`=1, sampling moves to the following falling edge and `byte_valid` is seen with SCK low.
- R10: Each SCK high phase and each SCK low phase lasts 2^`rate_sel` system clocks.
- R11: When `stop` is raised during a read, the byte in progress completes. SCK then returns low, `cs_n` rises with `io0_oe` low, `busy` drops, and no further byte is delivered.
- R12: Each received byte gives `byte_valid` high for exactly one clock, with the byte on `byte_data` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a read when idle |
| start_addr | input | 32 | Flash address of the first byte |
| addr32 | input | 1 | 1 selects a 32-bit address phase, 0 a 24-bit one |
| rate_sel | input | RATE_W | SCK half period is 2^rate_sel clocks |
| fall_capture | input | 1 | 1 samples data on SCK falling edges |
| width_req | input | 2 | Requested data width for later bytes |
| stop | input | 1 | Ends the read after the current byte |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| io0_o | output | 1 | IO0 output value |
| io0_oe | output | 1 | IO0 output enable |
| io0_i | input | 1 | IO0 input value |
| io1_i | input | 1 | IO1 input (flash data out) |
| io2_i | input | 1 | IO2 input, used in x4 |
| io3_i | input | 1 | IO3 input, used in x4 |
| byte_data | output | 8 | Assembled byte |
| byte_valid | output | 1 | One-clock strobe per byte |
| busy | output | 1 | High from start until the read ends |

## Verification
A bit counter or width register that goes wrong shows up at the byte following the fault, either as a wrong value or as `byte_valid` arriving a few SCK cycles early or late. A command counter that is off by one shifts every data byte by one bit, so the first byte already mismatches. The bench flash also stops answering if the command length is wrong. A late IO0 release is seen at the first wide SCK edge as the master and the model driving IO0 together. A capture edge or stop sequence that goes wrong is seen at once as SCK in the wrong phase during a strobe, or as one byte too many after a stop.

// File: rtl/spi_cfg_reader.sv
module spi_cfg_reader #(
  parameter int RATE_W  = 2,
  parameter bit WIDE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_addr,
  input  logic              addr32,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              fall_capture,
  input  logic [1:0]        width_req,
  input  logic              stop,
  output logic              sck,
  output logic              cs_n,
  output logic              io0_o,
  output logic              io0_oe,
  input  logic              io0_i,
  input  logic              io1_i,
  input  logic              io2_i,
  input  logic              io3_i,
  output logic [7:0]        byte_data,
  output logic              byte_valid,
  output logic              busy
);
  localparam int CNT_W = (2 ** RATE_W) - 1;
  localparam logic [7:0] RD_OP = 8'h03;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_CMD, S_DATA, S_FIN} st_t;

  st_t              state;
  logic             sck_q, cs_q, oe_q, fcap_q, stop_q, bval_q;
  logic [CNT_W-1:0] cnt_q, half_q;
  logic [39:0]      cmd_q;
  logic [5:0]       left_q;
  logic [7:0]       sh_q, bdata_q, sh_nx;
  logic [3:0]       nbit_q, nbit_nx;
  logic [1:0]       wid_q;
  logic [CNT_W:0]   span;
  logic             tick, rise_ev, fall_ev, samp_ev;

  function automatic logic [1:0] pick_w(input logic [1:0] r);
    if (!WIDE_EN) return 2'b00;
    if (r[1]) return 2'b10;
    if (r[0]) return 2'b01;
    return 2'b00;
  endfunction

  assign span    = ((CNT_W+1)'(1) << rate_sel) - (CNT_W+1)'(1);
  assign tick    = (state != S_IDLE) && (cnt_q == half_q);
  assign rise_ev = tick && !sck_q;
  assign fall_ev = tick && sck_q;
  assign samp_ev = (state == S_DATA) && (fcap_q ? fall_ev : rise_ev);
  assign nbit_nx = nbit_q + ((wid_q == 2'b10) ? 4'd4 : (wid_q == 2'b01) ? 4'd2 : 4'd1);

  always_comb begin
    case (wid_q)
      2'b10:   sh_nx = {sh_q[3:0], io3_i, io2_i, io1_i, io0_i};
      2'b01:   sh_nx = {sh_q[5:0], io1_i, io0_i};
      default: sh_nx = {sh_q[6:0], io1_i};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      oe_q    <= 1'b0;
      fcap_q  <= 1'b0;
      stop_q  <= 1'b0;
      bval_q  <= 1'b0;
      cnt_q   <= '0;
      half_q  <= '0;
      cmd_q   <= '0;
      left_q  <= '0;
      sh_q    <= '0;
      bdata_q <= '0;
      nbit_q  <= '0;
      wid_q   <= 2'b00;
    end else begin
      bval_q <= 1'b0;
      if (state != S_IDLE) begin
        cnt_q <= tick ? '0 : cnt_q + 1'b1;
        if (tick) sck_q <= ~sck_q;
        if (stop) stop_q <= 1'b1;
      end
      case (state)
        S_IDLE: begin
          sck_q <= 1'b0;
          cnt_q <= '0;
          if (start) begin
            state  <= S_PRE;
            stop_q <= 1'b0;
            fcap_q <= fall_capture;
            half_q <= span[CNT_W-1:0];
            cmd_q  <= addr32 ? {RD_OP, start_addr} : {RD_OP, start_addr[23:0], 8'h00};
            left_q <= addr32 ? 6'd40 : 6'd32;
          end
        end
        S_PRE: begin
          if (fall_ev) begin
            cs_q  <= 1'b0;
            oe_q  <= 1'b1;
            state <= S_CMD;
          end
        end
        S_CMD: begin
          if (rise_ev) left_q <= left_q - 1'b1;
          if (fall_ev) begin
            if (left_q == 6'd0) begin
              state  <= S_DATA;
              oe_q   <= ~WIDE_EN;
              nbit_q <= '0;
              sh_q   <= '0;
              wid_q  <= 2'b00;
            end else begin
              cmd_q <= {cmd_q[38:0], 1'b0};
            end
          end
        end
        S_DATA: begin
          if (samp_ev) begin
            sh_q <= sh_nx;
            if (nbit_nx == 4'd8) begin
              nbit_q  <= '0;
              bdata_q <= sh_nx;
              bval_q  <= 1'b1;
              wid_q   <= pick_w(width_req);
              if (stop_q || stop) begin
                if (fcap_q) begin
                  cs_q  <= 1'b1;
                  oe_q  <= 1'b0;
                  state <= S_IDLE;
                end else begin
                  state <= S_FIN;
                end
              end
            end else begin
              nbit_q <= nbit_nx;
            end
          end
        end
        S_FIN: begin
          if (fall_ev) begin
            cs_q  <= 1'b1;
            oe_q  <= 1'b0;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sck        = sck_q;
  assign cs_n       = cs_q;
  assign io0_o      = cmd_q[39];
  assign io0_oe     = oe_q;
  assign byte_data  = bdata_q;
  assign byte_valid = bval_q;
  assign busy       = (state != S_IDLE);
endmodule

// File: rtl/spi_cfg_reader_chk.sv
module spi_cfg_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_n,
  input logic io0_o,
  input logic io0_oe,
  input logic byte_valid,
  input logic busy
);
  assert_cs_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_cs_fall_sck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sck);

  assert_io0_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck) && io0_oe && $past(io0_oe)) |-> $stable(io0_o));

  assert_oe_release_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(io0_oe) && !cs_n) |-> !sck);

  assert_end_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sck && !io0_oe));

  assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
endmodule

bind spi_cfg_reader spi_cfg_reader_chk u_chk (.*);

// File: tb/tb_spi_cfg_reader.sv
`timescale 1ns/1ps
module tb_spi_cfg_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        addr32 = 1'b0;
  logic [1:0]  rate_sel = '0;
  logic        fall_capture = 1'b0;
  logic [1:0]  width_req = '0;
  logic        stop = 1'b0;
  logic        sck, cs_n, io0_o, io0_oe, io0_i;
  logic        fl0 = 1'b0, fl1 = 1'b0, fl2 = 1'b0, fl3 = 1'b0;
  logic [7:0]  byte_data;
  logic        byte_valid, busy;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  assign io0_i = io0_oe ? io0_o : fl0;

  spi_cfg_reader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .addr32(addr32), .rate_sel(rate_sel), .fall_capture(fall_capture),
    .width_req(width_req), .stop(stop), .sck(sck), .cs_n(cs_n),
    .io0_o(io0_o), .io0_oe(io0_oe), .io0_i(io0_i), .io1_i(fl1),
    .io2_i(fl2), .io3_i(fl3), .byte_data(byte_data),
    .byte_valid(byte_valid), .busy(busy)
  );

  function automatic logic [7:0] fdat(input int k);
    return 8'((k * 29 + 167) ^ (k * 7));
  endfunction

  function automatic int wbits(input logic [1:0] c);
    if (c[1]) return 4;
    if (c[0]) return 2;
    return 1;
  endfunction

  // flash model
  int          ncmd = 32;
  int          wsched [64];
  logic [39:0] rxcmd = '0;
  int          rxn = 0, bidx = 0, boff = 0, pre_cnt = 0, clash = 0;

  always @(posedge cs_n) begin rxn = 0; bidx = 0; boff = 0; end

  always @(posedge sck) begin
    if (cs_n) pre_cnt++;
    else if (rxn < ncmd) begin rxcmd = {rxcmd[38:0], io0_o}; rxn++; end
  end

  always @(negedge sck) begin
    if (!cs_n && rxn == ncmd && bidx < 64) begin
      #2;
      begin
        automatic int w = wsched[bidx];
        automatic logic [7:0] b = fdat(bidx);
        automatic int p = 7 - boff;
        if (w == 1) begin
          fl1 = b[p]; fl0 = ~b[p]; fl2 = b[p]; fl3 = ~b[p];
        end else if (w == 2) begin
          fl1 = b[p]; fl0 = b[p-1]; fl2 = ~b[p]; fl3 = b[p-1];
          if (io0_oe) clash++;
        end else begin
          fl3 = b[p]; fl2 = b[p-1]; fl1 = b[p-2]; fl0 = b[p-3];
          if (io0_oe) clash++;
        end
        boff += w;
        if (boff >= 8) begin boff = 0; bidx++; end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired: actual hung run, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [1:0]  req_plan [64];
  logic [7:0]  got [64];
  logic        ph [64];

  task automatic run_read(input logic [31:0] a, input bit a32, input logic [1:0] rate,
                          input bit fc, input int nstop, input string tag);
    int nb = 0, hi = 0, lasthi = 0, csmid = 0, dbl = 0, pre0, con0;
    bit seen_low = 0, prev_bv = 0;
    logic [39:0] expc;
    ncmd = a32 ? 40 : 32;
    wsched[0] = 1;
    for (int k = 1; k < 64; k++) wsched[k] = wbits(req_plan[k-1]);
    pre0 = pre_cnt; con0 = clash;
    start_addr = a; addr32 = a32; rate_sel = rate; fall_capture = fc;
    width_req = req_plan[0];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    forever begin
      if (byte_valid) begin
        if (nb < 64) begin got[nb] = byte_data; ph[nb] = sck; end
        nb++;
        if (nb < 64) width_req = req_plan[nb];
        if (nb == nstop - 1) stop = 1'b1;
        if (prev_bv) dbl++;
      end
      prev_bv = byte_valid;
      if (!cs_n) seen_low = 1;
      else if (seen_low && busy) csmid++;
      if (sck) hi++;
      else begin if (hi > 0) lasthi = hi; hi = 0; end
      if (!busy) break;
      @(negedge clk);
    end
    stop = 1'b0;
    expc = a32 ? {8'h03, a} : {8'h00, 8'h03, a[23:0]};
    check(rxn == 0 && rxcmd[39:0] == (a32 ? expc : {rxcmd[39:32], expc[31:0]}),
          a32 ? "R4" : "R3", {tag, " command bits"},
          a32 ? rxcmd : {8'h00, rxcmd[31:0]}, expc);
    check(nb == nstop, "R11", {tag, " bytes before stop"}, nb, nstop);
    for (int k = 0; k < nb && k < 64; k++)
      check(got[k] == fdat(k), (k == 0) ? "R5" : "R6", {tag, " byte value"}, got[k], fdat(k));
    for (int k = 0; k < nb && k < 64; k++)
      check(ph[k] == !fc, "R9", {tag, " sck phase at strobe"}, ph[k], !fc);
    check(lasthi == (1 << rate), "R10", {tag, " sck half period"}, lasthi, 1 << rate);
    check(cs_n && !sck && !io0_oe && !busy, "R11", {tag, " idle pins after stop"},
          {cs_n, sck, io0_oe, busy}, 4'b1000);
    check(pre_cnt - pre0 == 1, "R2", {tag, " sck rises before select"}, pre_cnt - pre0, 1);
    check(clash == con0, "R8", {tag, " io0 contention"}, clash - con0, 0);
    check(csmid == 0, "R7", {tag, " select held across read"}, csmid, 0);
    check(dbl == 0, "R12", {tag, " strobe width"}, dbl, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset;
    @(negedge clk);
    check(cs_n && !sck && !io0_oe && !busy && !byte_valid, "R1", "reset state",
          {cs_n, sck, io0_oe, busy, byte_valid}, 5'b10000);
  endtask

  task automatic test_plain_x1;
    for (int k = 0; k < 64; k++) req_plan[k] = 2'b00;
    run_read(32'hFFA5C3F1, 1'b0, 2'd0, 1'b0, 4, "x1 24-bit rise");
  endtask

  task automatic test_addr32_dual;
    for (int k = 0; k < 64; k++) req_plan[k] = 2'b01;
    run_read(32'h12345678, 1'b1, 2'd2, 1'b1, 5, "x2 32-bit fall");
  endtask

  task automatic test_width_mix;
    for (int k = 0; k < 64; k++) req_plan[k] = 2'b10;
    req_plan[1] = 2'b01; req_plan[2] = 2'b00; req_plan[3] = 2'b11; req_plan[5] = 2'b01;
    run_read(32'h00FF0F00, 1'b0, 2'd3, 1'b0, 8, "R7 mixed widths");
  endtask

  task automatic test_quad_fast;
    for (int k = 0; k < 64; k++) req_plan[k] = 2'b10;
    run_read(32'h80000001, 1'b1, 2'd0, 1'b1, 6, "x4 fall fast");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset;
    test_plain_x1;
    test_addr32_dual;
    test_width_mix;
    test_quad_fast;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule